// File: doc/BRIEF.md
# Flash Controller Reset Sequencer

This block sits in front of an embedded flash controller. It decides which of three active-low reset sources is in charge and then walks the controller back to an operable state. Power-on reset wins over everything and also clears a sticky inhibit flag. Master reset comes next. It runs a fixed recovery: a safe high-voltage shutdown if a program or erase is active, then one cycle of register clear plus shadow reload, then bus-interface ready. System reset ranks lowest. It only drops the high-voltage enable and holds the bus interface off while it lasts.

The sticky inhibit flag, once set, makes both master and system reset invisible. The charge pump is represented by a request/done handshake. Register access is modelled as a request that completes after a latency set by a 2-bit wait code, and it is stalled whenever a reset sequence is running. Master and system reset are passed through two-flop synchronizers before arbitration. Power-on reset clears every flop asynchronously.

Top module: `flash_rst_seq`

## Requirements
- R1: While `por_n` is low: `biu_rdy_o`=0, `acc_block_o`=1, `shadow_ld_o`=0, `inhibit_o`=0 and `ehv_o`=0. In the first clock after release `shadow_ld_o` is 1 and `biu_rdy_o` is 0. In the second clock `biu_rdy_o` is 1 and `shadow_ld_o` is 0.
- R2: A high on `inh_set_i` sets `inhibit_o` on the next clock edge. It stays set until power-on reset.
- R3: With the inhibit flag clear, a master reset gives exactly one cycle with both `shadow_ld_o` and `reg_clr_o` high. `biu_rdy_o` falls on the third clock edge after `mrst_n` falls.
- R4: If `ehv_o` is 1 when master reset takes effect, `hv_off_req_o` stays high until a cycle with `hv_done_i`=1. It is high for exactly as many cycles as it takes the handshake to arrive. `shadow_ld_o` is never high while `hv_off_req_o` is high, and `ehv_o` is 0 after the sequence.
- R5: After `mrst_n` rises, `biu_rdy_o` is still 0 two clock edges later and is 1 on the third edge, well inside a 4-clock bound.
- R6: `mrst_short_o` pulses for one cycle on the third edge after `mrst_n` rises when master reset was low for fewer than `MIN_MRST_CLKS` (512) clocks. A pulse of exactly 512 clocks or longer raises no flag.
- R7: With the inhibit flag set, a master reset is ignored: no shadow load, `biu_rdy_o` stays 1, `ehv_o` keeps its value and no short-pulse flag is raised.
- R8: With the inhibit flag clear, a system reset raises `sel_clr_o` and clears `ehv_o`. `biu_rdy_o` falls on the third edge after `srst_n` falls and returns on the third edge after it rises. No shadow load occurs and the inhibit flag is untouched.
- R9: With the inhibit flag set, a system reset is ignored: no `sel_clr_o`, `biu_rdy_o` stays 1 and `ehv_o` keeps its value.
- R10: A master reset arriving during a system reset starts the master sequence, including one shadow load. A system reset arriving during a master sequence produces no `sel_clr_o`.
- R11: With `biu_rdy_o`=1 and `acc_req_i` held from a clock edge on, `acc_done_o` goes high in the (2+`wait_sel_i`)-th clock, i.e. `wait_sel_i`+1 edges after the request. It never goes high while `acc_block_o`=1.
- R12: `ehv_set_i` high in a ready cycle sets `ehv_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous clear |
| mrst_n | input | 1 | Master reset request, active low, asynchronous |
| srst_n | input | 1 | System reset request, active low, asynchronous |
| inh_set_i | input | 1 | Sets the sticky reset-inhibit flag |
| ehv_set_i | input | 1 | Marks a program/erase as started (sets high-voltage enable) |
| hv_done_i | input | 1 | High-voltage discharge finished handshake |
| acc_req_i | input | 1 | Register access request, held until done |
| wait_sel_i | input | WAIT_W | Wait-state code added to the 2-clock base access |
| hv_off_req_o | output | 1 | Request to discharge the high voltage |
| shadow_ld_o | output | 1 | Single-cycle shadow configuration reload strobe |
| reg_clr_o | output | 1 | Full register clear to defaults |
| sel_clr_o | output | 1 | Selective clear of the high-voltage enable |
| biu_rdy_o | output | 1 | Bus interface ready for the first access |
| acc_block_o | output | 1 | Register access blocked by a reset sequence |
| acc_done_o | output | 1 | Register access completes this cycle |
| mrst_short_o | output | 1 | Master reset pulse was shorter than the minimum |
| inhibit_o | output | 1 | Current sticky reset-inhibit flag |
| ehv_o | output | 1 | Current high-voltage enable state |

## Verification
The bench targets the order of the master recovery. A design that loads the shadow before the discharge handshake, or keeps the discharge request after it, shows up through the handshake cycle count and the overlap counter. It probes the 511 and 512 clock master pulses, where an off-by-one length counter flags the wrong one. It also checks the exact edge where ready returns, which exposes an extra or missing pipeline stage. It crosses the two reset levels in both orders and applies both resets with the inhibit flag set. A wrong priority then shows as a missing shadow load, a spurious selective clear, or a lost high-voltage enable.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  // Sequencer states, in recovery order.
  typedef enum logic [2:0] {
    ST_PORW  = 3'd0,
    ST_READY = 3'd1,
    ST_MHV   = 3'd2,
    ST_MSHD  = 3'd3,
    ST_MHOLD = 3'd4,
    ST_SRST  = 3'd5
  } seq_st_t;

  // Total clocks an access occupies for a given wait code.
  function automatic logic [31:0] acc_latency(input logic [31:0] wait_code);
    return 32'd2 + wait_code;
  endfunction

  // A master pulse counted over len clocks is too short.
  function automatic logic is_short(input logic [31:0] len, input logic [31:0] min_len);
    return len < min_len;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] async_n,
  output logic [WIDTH-1:0] sync_n
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] stg;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= '1;
      else         stg <= {stg[STAGES-2:0], async_n[i]};
    end
    assign sync_n[i] = stg[STAGES-1];
  end

endmodule

// File: rtl/pulse_len_mon.sv
module pulse_len_mon
  import flash_rst_pkg::*;
#(
  parameter int unsigned MIN_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic short_err
);

  localparam int unsigned CW = $clog2(MIN_LEN + 1);

  logic [CW-1:0] len_cnt;
  logic          act_q;
  logic          act_fall;

  assign act_fall = act_q && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_cnt   <= '0;
      act_q     <= 1'b0;
      short_err <= 1'b0;
    end else begin
      act_q     <= active;
      short_err <= act_fall && is_short(32'(len_cnt), 32'(MIN_LEN));
      if (active) begin
        if (len_cnt != CW'(MIN_LEN)) len_cnt <= len_cnt + 1'b1;
      end else begin
        len_cnt <= '0;
      end
    end
  end

  // R6
  short_err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> !short_err);

  // R6
  short_err_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> !active);

endmodule

// File: rtl/acc_timer.sv
module acc_timer
  import flash_rst_pkg::*;
#(
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req,
  input  logic [WAIT_W-1:0] wait_sel,
  output logic              done
);

  localparam int unsigned MAX_LAT = 1 + (1 << WAIT_W);
  localparam int unsigned CW      = $clog2(MAX_LAT + 1);

  logic [CW-1:0] cyc_cnt;
  logic [CW-1:0] last_cyc;

  assign last_cyc = CW'(acc_latency(32'(wait_sel)) - 32'd1);
  assign done     = enable && req && (cyc_cnt == last_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cyc_cnt <= '0;
    else if (!enable || !req || done)  cyc_cnt <= '0;
    else                               cyc_cnt <= cyc_cnt + 1'b1;
  end

  // R11
  acc_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  acc_done_needs_prior_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req) && $past(enable));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import flash_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic m_sync_n,
  input  logic s_sync_n,
  input  logic inh_set,
  input  logic ehv_set,
  input  logic hv_done,
  output logic m_act,
  output logic hv_off_req,
  output logic shadow_ld,
  output logic reg_clr,
  output logic sel_clr,
  output logic biu_rdy,
  output logic acc_block,
  output logic inhibit,
  output logic ehv
);

  seq_st_t st, st_nx;
  logic    s_act;
  logic    ehv_drop;
  logic    ehv_take;

  assign m_act = !m_sync_n && !inhibit;
  assign s_act = !s_sync_n && !inhibit;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_PORW:  st_nx = ST_MSHD;
      ST_READY: begin
        if (m_act)      st_nx = ST_MHV;
        else if (s_act) st_nx = ST_SRST;
      end
      ST_MHV:   if (!ehv || hv_done) st_nx = ST_MSHD;
      ST_MSHD:  st_nx = m_act ? ST_MHOLD : ST_READY;
      ST_MHOLD: if (!m_act) st_nx = ST_READY;
      ST_SRST: begin
        if (m_act)       st_nx = ST_MHV;
        else if (!s_act) st_nx = ST_READY;
      end
      default:  st_nx = ST_READY;
    endcase
  end

  assign ehv_drop = ((st == ST_MHV) && hv_done) || (st == ST_SRST);
  assign ehv_take = ehv_set && (st == ST_READY) && !m_act && !s_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PORW;
      inhibit <= 1'b0;
      ehv     <= 1'b0;
    end else begin
      st <= st_nx;
      if (inh_set) inhibit <= 1'b1;
      if (ehv_drop)      ehv <= 1'b0;
      else if (ehv_take) ehv <= 1'b1;
    end
  end

  assign hv_off_req = (st == ST_MHV) && ehv;
  assign shadow_ld  = (st == ST_MSHD);
  assign reg_clr    = (st == ST_MSHD);
  assign sel_clr    = (st == ST_SRST);
  assign biu_rdy    = (st == ST_READY);
  assign acc_block  = (st != ST_READY);

  // R3
  shadow_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_ld |=> !shadow_ld);

  // R4
  shadow_after_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_ld |-> !ehv);

  // R4
  hv_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_off_req && !hv_done) |=> hv_off_req);

  // R2
  inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit) |-> inhibit);

  // R8
  sel_clr_drops_ehv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_clr |=> !ehv);

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int unsigned MIN_MRST_CLKS = 512,
  parameter int unsigned WAIT_W        = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              srst_n,
  input  logic              inh_set_i,
  input  logic              ehv_set_i,
  input  logic              hv_done_i,
  input  logic              acc_req_i,
  input  logic [WAIT_W-1:0] wait_sel_i,
  output logic              hv_off_req_o,
  output logic              shadow_ld_o,
  output logic              reg_clr_o,
  output logic              sel_clr_o,
  output logic              biu_rdy_o,
  output logic              acc_block_o,
  output logic              acc_done_o,
  output logic              mrst_short_o,
  output logic              inhibit_o,
  output logic              ehv_o
);

  logic [1:0] rst_sync_n;
  logic       m_act;

  rst_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .async_n ({srst_n, mrst_n}),
    .sync_n  (rst_sync_n)
  );

  rst_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (por_n),
    .m_sync_n   (rst_sync_n[0]),
    .s_sync_n   (rst_sync_n[1]),
    .inh_set    (inh_set_i),
    .ehv_set    (ehv_set_i),
    .hv_done    (hv_done_i),
    .m_act      (m_act),
    .hv_off_req (hv_off_req_o),
    .shadow_ld  (shadow_ld_o),
    .reg_clr    (reg_clr_o),
    .sel_clr    (sel_clr_o),
    .biu_rdy    (biu_rdy_o),
    .acc_block  (acc_block_o),
    .inhibit    (inhibit_o),
    .ehv        (ehv_o)
  );

  pulse_len_mon #(
    .MIN_LEN (MIN_MRST_CLKS)
  ) u_len (
    .clk       (clk),
    .rst_n     (por_n),
    .active    (m_act),
    .short_err (mrst_short_o)
  );

  acc_timer #(
    .WAIT_W (WAIT_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (por_n),
    .enable   (biu_rdy_o),
    .req      (acc_req_i),
    .wait_sel (wait_sel_i),
    .done     (acc_done_o)
  );

  // R11
  no_access_when_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
    acc_block_o |-> !acc_done_o);

  // R10
  no_selclr_with_shadow_chk: assert property (@(posedge clk) disable iff (!por_n)
    shadow_ld_o |-> !sel_clr_o);

endmodule

// File: tb/flash_rst_seq_bench.sv
module flash_rst_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_LEN    = 512;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       mrst_n = 1'b1;
  logic       srst_n = 1'b1;
  logic       inh_set_i = 1'b0;
  logic       ehv_set_i = 1'b0;
  logic       hv_done_i = 1'b0;
  logic       acc_req_i = 1'b0;
  logic [1:0] wait_sel_i = 2'd0;
  logic hv_off_req_o, shadow_ld_o, reg_clr_o, sel_clr_o, biu_rdy_o;
  logic acc_block_o, acc_done_o, mrst_short_o, inhibit_o, ehv_o;

  int tests = 0;
  int fails = 0;
  bit ehv_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rst_seq u_flash_rst_seq (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .srst_n(srst_n),
    .inh_set_i(inh_set_i), .ehv_set_i(ehv_set_i), .hv_done_i(hv_done_i),
    .acc_req_i(acc_req_i), .wait_sel_i(wait_sel_i),
    .hv_off_req_o(hv_off_req_o), .shadow_ld_o(shadow_ld_o), .reg_clr_o(reg_clr_o),
    .sel_clr_o(sel_clr_o), .biu_rdy_o(biu_rdy_o), .acc_block_o(acc_block_o),
    .acc_done_o(acc_done_o), .mrst_short_o(mrst_short_o),
    .inhibit_o(inhibit_o), .ehv_o(ehv_o)
  );

  function automatic int exp_acc_edges(input int w);
    // access spans 2+w clocks; done shows in its last clock
    return (2 + w) - 1;
  endfunction

  function automatic bit exp_short(input int len);
    return len < MIN_LEN;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ehv();
    ehv_set_i = 1'b1;
    step(1);
    ehv_set_i = 1'b0;
    ehv_m = 1'b1;
    chk("R12 ehv set", ehv_o, 1);
  endtask

  task automatic do_access(input int w);
    int n = 0;
    wait_sel_i = 2'(w);
    acc_req_i = 1'b1;
    while (!acc_done_o && n < 12) begin
      step(1);
      n++;
    end
    acc_req_i = 1'b0;
    chk("R11 access latency", n, exp_acc_edges(w));
    step(1);
    chk("R11 done drops", acc_done_o, 0);
  endtask

  task automatic do_master(input int len, input int d, input bit run);
    bit had = ehv_m;
    int shad = 0, rc = 0, hvc = 0, selc = 0, rdyh = 0, bad = 0;
    mrst_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      step(1);
      if (shadow_ld_o) shad++;
      if (reg_clr_o) rc++;
      if (sel_clr_o) selc++;
      if (biu_rdy_o) rdyh++;
      if (shadow_ld_o && hv_off_req_o) bad++;
      if (hv_off_req_o) begin
        hvc++;
        hv_done_i = (hvc >= d);
      end else begin
        hv_done_i = 1'b0;
      end
    end
    mrst_n = 1'b1;
    hv_done_i = 1'b0;
    step(2);
    chk("R5 ready not before 3rd edge", biu_rdy_o, run ? 0 : 1);
    chk("R6 no early flag", mrst_short_o, 0);
    step(1);
    chk("R5 ready at 3rd edge", biu_rdy_o, 1);
    chk("R6 short flag", mrst_short_o, (run && exp_short(len)) ? 1 : 0);
    chk("R10 no selective clear", selc, 0);
    if (run) begin
      chk("R3 one shadow load", shad, 1);
      chk("R3 one register clear", rc, 1);
      chk("R3 ready drops at 3rd edge", rdyh, 2);
      chk("R4 discharge cycles", hvc, had ? d : 0);
      chk("R4 no shadow during discharge", bad, 0);
      chk("R4 ehv cleared", ehv_o, 0);
      ehv_m = 1'b0;
    end else begin
      chk("R7 no shadow when inhibited", shad, 0);
      chk("R7 ready kept", rdyh, len);
      chk("R7 ehv kept", ehv_o, ehv_m);
    end
  endtask

  task automatic do_sys(input int len, input bit run, input bit with_acc);
    int selc = 0, shad = 0, rdyh = 0, dn = 0;
    wait_sel_i = 2'd0;
    srst_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      step(1);
      if (sel_clr_o) selc++;
      if (shadow_ld_o) shad++;
      if (biu_rdy_o) rdyh++;
      if (acc_done_o) dn++;
      if (with_acc && i == 3) acc_req_i = 1'b1;
    end
    srst_n = 1'b1;
    acc_req_i = 1'b0;
    step(2);
    chk("R8 ready held until 3rd edge", biu_rdy_o, run ? 0 : 1);
    step(1);
    chk("R8 ready back at 3rd edge", biu_rdy_o, 1);
    chk("R8 no shadow on system reset", shad, 0);
    if (run) begin
      chk("R8 selective clear seen", selc > 0, 1);
      chk("R8 ready drops at 3rd edge", rdyh, 2);
      chk("R8 ehv cleared", ehv_o, 0);
      ehv_m = 1'b0;
      if (with_acc) chk("R11 blocked access", dn, 0);
    end else begin
      chk("R9 no selective clear", selc, 0);
      chk("R9 ready kept", rdyh, len);
      chk("R9 ehv kept", ehv_o, ehv_m);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int shad, selc;
    void'($urandom(32'd7411));
    // R1 reset state
    step(3);
    chk("R1 ready low in reset", biu_rdy_o, 0);
    chk("R1 blocked in reset", acc_block_o, 1);
    chk("R1 no shadow in reset", shadow_ld_o, 0);
    chk("R1 inhibit clear", inhibit_o, 0);
    chk("R1 ehv clear", ehv_o, 0);
    por_n = 1'b1;
    step(1);
    chk("R1 shadow after release", shadow_ld_o, 1);
    chk("R1 not ready yet", biu_rdy_o, 0);
    step(1);
    chk("R1 ready", biu_rdy_o, 1);
    chk("R1 shadow single", shadow_ld_o, 0);

    for (int w = 0; w < 4; w++) do_access(w);

    // directed master pulse lengths around the minimum
    set_ehv();
    do_master(511, 3, 1'b1);
    do_master(MIN_LEN, 1, 1'b1);
    set_ehv();
    do_master(600, 6, 1'b1);
    do_sys(12, 1'b1, 1'b1);

    // R10 master during system reset
    set_ehv();
    srst_n = 1'b0;
    step(6);
    chk("R8 selective clear active", sel_clr_o, 1);
    mrst_n = 1'b0;
    shad = 0;
    for (int i = 0; i < 12; i++) begin step(1); if (shadow_ld_o) shad++; end
    srst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin step(1); if (shadow_ld_o) shad++; end
    mrst_n = 1'b1;
    step(3);
    chk("R10 master overrides system", shad, 1);
    chk("R10 ready after", biu_rdy_o, 1);
    ehv_m = 1'b0;

    // R10 system during master
    mrst_n = 1'b0;
    selc = 0;
    shad = 0;
    step(8);
    srst_n = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); if (sel_clr_o) selc++; if (shadow_ld_o) shad++; end
    srst_n = 1'b1;
    for (int i = 0; i < 15; i++) begin step(1); if (sel_clr_o) selc++; if (shadow_ld_o) shad++; end
    mrst_n = 1'b1;
    step(3);
    chk("R10 system ignored in master", selc, 0);
    chk("R10 ready after", biu_rdy_o, 1);

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op = int'($urandom_range(0, 3));
      case (op)
        0: do_access(int'($urandom_range(0, 3)));
        1: do_sys(int'($urandom_range(5, 20)), 1'b1, 1'($urandom_range(0, 1)));
        2: begin
          if ($urandom_range(0, 1) == 1) set_ehv();
          do_master(int'($urandom_range(20, 60)), int'($urandom_range(1, 5)), 1'b1);
        end
        default: set_ehv();
      endcase
      step(int'($urandom_range(1, 4)));
    end

    // R2 / R7 / R9 inhibit phase
    inh_set_i = 1'b1;
    step(1);
    inh_set_i = 1'b0;
    chk("R2 inhibit set", inhibit_o, 1);
    set_ehv();
    do_master(40, 1, 1'b0);
    do_sys(10, 1'b0, 1'b0);
    chk("R2 inhibit sticky", inhibit_o, 1);

    // R1 power-on reset clears the inhibit flag
    por_n = 1'b0;
    step(1);
    chk("R1 inhibit cleared", inhibit_o, 0);
    chk("R1 ehv cleared", ehv_o, 0);
    chk("R1 ready low", biu_rdy_o, 0);
    por_n = 1'b1;
    ehv_m = 1'b0;
    step(2);
    chk("R1 ready after second release", biu_rdy_o, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule